// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block steers data movement between a volatile SRAM array and the nonvolatile shadow array behind it. A save operation (store) first wipes the shadow cells and then writes the current SRAM image into them. A restore operation (recall) first blanks the SRAM and then loads it from the shadow cells. Each step is signalled to the array models by a strobe that stays high for a parameterised number of clock cycles.

Store requests can come from a software sequence detector, from a rising edge on a hardware store strobe, or from the supply-good flag dropping. Recall requests can come from the software detector, from the supply-good flag returning, or from the first cycles after reset. A single arbiter picks one request at a time and gives store first claim. While an operation runs, a busy output locks out ordinary SRAM reads and writes. A one-cycle completion pulse marks the end of each operation.

Top module: `nv_xfer_seq`

## Requirements
- R1: A store drives `erase_stb` for exactly ERASE_CYC consecutive cycles and then `program_stb` for exactly PROG_CYC cycles. At most one of the four strobes is high in any cycle.
- R2: A recall drives `clear_stb` for exactly CLEAR_CYC cycles and then `load_stb` for exactly LOAD_CYC cycles. `erase_stb` and `program_stb` stay low for the whole recall, so the shadow contents are untouched.
- R3: A store is requested by `sw_store_req` high at a clock edge, by a 0-to-1 change of `hw_store`, or by a 1-to-0 change of `supply_ok`. The previous-value register for `supply_ok` resets to 1 and the one for `hw_store` resets to 0.
- R4: A recall is requested by `sw_recall_req` high at a clock edge or by a 0-to-1 change of `supply_ok`. One recall is also requested automatically after reset is released, and that request stays pending until a recall is accepted.
- R5: A request is accepted at a clock edge where the block is idle. `busy` is high from the cycle after that edge through the last cycle of the second phase, so it lasts ERASE_CYC+PROG_CYC cycles for a store and CLEAR_CYC+LOAD_CYC cycles for a recall.
- R6: When a store request and a recall request are present at the same idle edge, the store is run.
- R7: While busy, software requests, `hw_store` edges and `supply_ok` rises are dropped. A `supply_ok` fall is latched instead, and its store is accepted at the edge that ends the done cycle.
- R8: `done` is high for exactly one cycle, the cycle right after the last cycle of the second phase, with `busy` low in that cycle.
- R9: While `rst` is high, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_store_req | input | 1 | Software store request, sampled at each edge |
| sw_recall_req | input | 1 | Software recall request, sampled at each edge |
| hw_store | input | 1 | Hardware store strobe; a rising edge requests a store |
| supply_ok | input | 1 | Supply above threshold; a fall requests a store, a rise requests a recall |
| busy | output | 1 | Operation in progress; ordinary SRAM access is blocked |
| erase_stb | output | 1 | Erase shadow cells (store, first phase) |
| program_stb | output | 1 | Program shadow cells from SRAM (store, second phase) |
| clear_stb | output | 1 | Clear SRAM (recall, first phase) |
| load_stb | output | 1 | Load SRAM from shadow cells (recall, second phase) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that reset is held high for at least one clock edge before it is released, and that every input changes only between clock edges. They check the handover from the first strobe to the second, that only one strobe is active at a time, and how `done` lines up with `busy`. The bench holds reset for several cycles and drives all inputs on the falling clock edge. Its random stimulus makes supply transitions rare and software and strobe requests more frequent, so that requests often arrive while the block is busy.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;

    typedef enum logic {
        OP_STORE  = 1'b0,
        OP_RECALL = 1'b1
    } op_e;

    typedef struct packed {
        phase_e phase;
        op_e    op;
    } seq_state_t;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/nv_trig_front.sv
module nv_trig_front (
    input  logic clk,
    input  logic rst,
    input  logic hw_store,
    input  logic supply_ok,
    output logic hw_rise,
    output logic sup_fall,
    output logic sup_rise
);
    logic hw_q;
    logic sup_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hw_q  <= 1'b0;
            sup_q <= 1'b1;
        end else begin
            hw_q  <= hw_store;
            sup_q <= supply_ok;
        end
    end

    assign hw_rise  = hw_store & ~hw_q;
    assign sup_fall = sup_q & ~supply_ok;
    assign sup_rise = ~sup_q & supply_ok;
endmodule

// File: rtl/nv_req_arb.sv
module nv_req_arb (
    input  logic clk,
    input  logic rst,
    input  logic idle,
    input  logic sw_store,
    input  logic sw_recall,
    input  logic hw_rise,
    input  logic sup_fall,
    input  logic sup_rise,
    output logic pick_store,
    output logic pick_recall
);
    logic fall_pend;
    logic boot_pend;
    logic want_store;
    logic want_recall;

    assign want_store  = sw_store | hw_rise | sup_fall | fall_pend;
    assign want_recall = sw_recall | sup_rise | boot_pend;

    assign pick_store  = idle & want_store;
    assign pick_recall = idle & ~want_store & want_recall;

    always_ff @(posedge clk) begin
        if (rst) begin
            fall_pend <= 1'b0;
            boot_pend <= 1'b1;
        end else begin
            if (pick_store)
                fall_pend <= 1'b0;
            else if (!idle && sup_fall)
                fall_pend <= 1'b1;
            if (pick_recall)
                boot_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/nv_phase_timer.sv
module nv_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic [CW-1:0] limit,
    output logic          last
);
    logic [CW-1:0] cnt;

    assign last = (cnt == limit - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || hold || last)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq
    import nv_seq_pkg::*;
#(
    parameter int ERASE_CYC = 4,
    parameter int PROG_CYC  = 5,
    parameter int CLEAR_CYC = 3,
    parameter int LOAD_CYC  = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_store_req,
    input  logic sw_recall_req,
    input  logic hw_store,
    input  logic supply_ok,
    output logic busy,
    output logic erase_stb,
    output logic program_stb,
    output logic clear_stb,
    output logic load_stb,
    output logic done
);
    localparam int MAXLEN = int'(max4(ERASE_CYC, PROG_CYC, CLEAR_CYC, LOAD_CYC));
    localparam int CW     = $clog2(MAXLEN + 1);

    seq_state_t    st;
    logic          idle;
    logic          hw_rise, sup_fall, sup_rise;
    logic          pick_store, pick_recall;
    logic          last;
    logic [CW-1:0] limit;
    logic          done_q;

    assign idle = (st.phase == PH_IDLE);

    nv_trig_front u_front (
        .clk       (clk),
        .rst       (rst),
        .hw_store  (hw_store),
        .supply_ok (supply_ok),
        .hw_rise   (hw_rise),
        .sup_fall  (sup_fall),
        .sup_rise  (sup_rise)
    );

    nv_req_arb u_arb (
        .clk         (clk),
        .rst         (rst),
        .idle        (idle),
        .sw_store    (sw_store_req),
        .sw_recall   (sw_recall_req),
        .hw_rise     (hw_rise),
        .sup_fall    (sup_fall),
        .sup_rise    (sup_rise),
        .pick_store  (pick_store),
        .pick_recall (pick_recall)
    );

    always_comb begin
        unique case ({st.op, st.phase == PH_SECOND})
            {OP_STORE,  1'b0}: limit = CW'(ERASE_CYC);
            {OP_STORE,  1'b1}: limit = CW'(PROG_CYC);
            {OP_RECALL, 1'b0}: limit = CW'(CLEAR_CYC);
            default:           limit = CW'(LOAD_CYC);
        endcase
    end

    nv_phase_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .hold  (idle),
        .limit (limit),
        .last  (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '{phase: PH_IDLE, op: OP_STORE};
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st.phase)
                PH_IDLE: begin
                    if (pick_store)
                        st <= '{phase: PH_FIRST, op: OP_STORE};
                    else if (pick_recall)
                        st <= '{phase: PH_FIRST, op: OP_RECALL};
                end
                PH_FIRST: begin
                    if (last) st.phase <= PH_SECOND;
                end
                PH_SECOND: begin
                    if (last) begin
                        st.phase <= PH_IDLE;
                        done_q   <= 1'b1;
                    end
                end
                default: st.phase <= PH_IDLE;
            endcase
        end
    end

    assign busy        = ~idle;
    assign erase_stb   = (st.phase == PH_FIRST)  && (st.op == OP_STORE);
    assign program_stb = (st.phase == PH_SECOND) && (st.op == OP_STORE);
    assign clear_stb   = (st.phase == PH_FIRST)  && (st.op == OP_RECALL);
    assign load_stb    = (st.phase == PH_SECOND) && (st.op == OP_RECALL);
    assign done        = done_q;
endmodule

// File: rtl/nv_xfer_seq_chk.sv
module nv_xfer_seq_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic erase_stb,
    input logic program_stb,
    input logic clear_stb,
    input logic load_stb,
    input logic done
);
    // R1 and R2: never two strobes at once
    assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({erase_stb, program_stb, clear_stb, load_stb}));

    // R1: erase hands over directly to program
    assert_erase_then_program_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(erase_stb) |-> program_stb);

    // R2: clear hands over directly to load
    assert_clear_then_load_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(clear_stb) |-> load_stb);

    // R2: recall never touches the shadow array
    assert_recall_keeps_nv_R2: assert property (@(posedge clk) disable iff (rst)
        (clear_stb || load_stb) |=> !erase_stb && !program_stb);

    // R8: done is a single-cycle pulse
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: done follows the end of busy, with busy low
    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R5: second-phase end drops busy
    assert_second_end_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(program_stb) || $fell(load_stb)) |-> (done && !busy));
endmodule

bind nv_xfer_seq nv_xfer_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .erase_stb   (erase_stb),
    .program_stb (program_stb),
    .clear_stb   (clear_stb),
    .load_stb    (load_stb),
    .done        (done)
);

// File: tb/sim_nv_xfer_seq.sv
module sim_nv_xfer_seq;
    localparam int E_C = 4;
    localparam int P_C = 5;
    localparam int C_C = 3;
    localparam int L_C = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw_s = 1'b0, sw_r = 1'b0, hw = 1'b0, sup = 1'b1;
    logic busy, erase_stb, program_stb, clear_stb, load_stb, done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    nv_xfer_seq #(.ERASE_CYC(E_C), .PROG_CYC(P_C), .CLEAR_CYC(C_C), .LOAD_CYC(L_C)) u0 (
        .clk(clk), .rst(rst), .sw_store_req(sw_s), .sw_recall_req(sw_r),
        .hw_store(hw), .supply_ok(sup), .busy(busy), .erase_stb(erase_stb),
        .program_stb(program_stb), .clear_stb(clear_stb), .load_stb(load_stb), .done(done)
    );

    // reference model state: phase 0 idle, 1 first, 2 second; op 0 store, 1 recall
    int   m_ph, m_cnt;
    logic m_op, m_done, m_pend, m_boot, m_supq, m_hwq;

    function automatic int phase_len(input logic op, input int ph);
        if (op == 1'b0) return (ph == 1) ? E_C : P_C;
        return (ph == 1) ? C_C : L_C;
    endfunction

    task automatic model_reset();
        m_ph = 0; m_cnt = 0; m_op = 1'b0; m_done = 1'b0;
        m_pend = 1'b0; m_boot = 1'b1; m_supq = 1'b1; m_hwq = 1'b0;
    endtask

    task automatic model_step();
        logic fall, rise, hwr, st_req, rc_req;
        fall   = m_supq & ~sup;
        rise   = ~m_supq & sup;
        hwr    = hw & ~m_hwq;
        st_req = sw_s | hwr | fall | m_pend;
        rc_req = sw_r | rise | m_boot;
        m_done = 1'b0;
        if (m_ph == 0) begin
            if (st_req) begin
                m_ph = 1; m_op = 1'b0; m_cnt = 0; m_pend = 1'b0;
            end else if (rc_req) begin
                m_ph = 1; m_op = 1'b1; m_cnt = 0; m_boot = 1'b0;
            end
        end else begin
            if (fall) m_pend = 1'b1;
            if (m_cnt == phase_len(m_op, m_ph) - 1) begin
                m_cnt = 0;
                if (m_ph == 2) begin m_ph = 0; m_done = 1'b1; end
                else m_ph = 2;
            end else begin
                m_cnt++;
            end
        end
        m_supq = sup;
        m_hwq  = hw;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // compare current outputs with model (called at negedge)
    task automatic compare_all();
        chk("R5 busy",        busy,        m_ph != 0);
        chk("R1 erase_stb",   erase_stb,   m_ph == 1 && m_op == 1'b0);
        chk("R1 program_stb", program_stb, m_ph == 2 && m_op == 1'b0);
        chk("R2 clear_stb",   clear_stb,   m_ph == 1 && m_op == 1'b1);
        chk("R2 load_stb",    load_stb,    m_ph == 2 && m_op == 1'b1);
        chk("R8 done",        done,        m_done);
    endtask

    // one cycle: compare, apply inputs, advance model
    task automatic cyc(input logic s, input logic r, input logic h, input logic p);
        @(negedge clk);
        compare_all();
        sw_s = s; sw_r = r; hw = h; sup = p;
        model_step();
    endtask

    task automatic run_idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, hw, sup);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        model_reset();
        repeat (4) begin
            @(negedge clk);
            // R9: outputs low during reset
            chk("R9 busy in reset", busy, 1'b0);
            chk("R9 strobes in reset", erase_stb | program_stb | clear_stb | load_stb, 1'b0);
            chk("R9 done in reset", done, 1'b0);
        end
        rst = 1'b0;
        model_step();                     // first edge after release: boot recall accepted
        // R4: automatic recall after reset
        @(negedge clk);
        chk("R4 boot recall clear_stb", clear_stb, 1'b1);
        compare_all();
        sw_s = 0; sw_r = 0; hw = 0; sup = 1;
        model_step();
        run_idle(C_C + L_C + 3);

        // R6: store and recall together -> store
        cyc(1'b1, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        chk("R6 store wins erase_stb", erase_stb, 1'b1);
        chk("R6 store wins clear_stb", clear_stb, 1'b0);
        compare_all();
        sw_s = 0; sw_r = 0; model_step();
        // R7: requests during busy dropped, supply fall latched
        cyc(1'b0, 1'b1, 1'b1, 1'b1);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);      // fall while busy
        run_idle(E_C + P_C);
        // R7: latched store follows done cycle
        @(negedge clk);
        chk("R7 pending store erase_stb", erase_stb, 1'b1);
        compare_all();
        model_step();
        run_idle(E_C + P_C + 3);

        // R4: supply rise requests recall; R3: hw edge requests store
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R4 rise recall clear_stb", clear_stb, 1'b1);
        compare_all();
        model_step();
        run_idle(C_C + L_C + 2);
        cyc(1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        chk("R3 hw edge erase_stb", erase_stb, 1'b1);
        compare_all();
        model_step();
        run_idle(E_C + P_C + 2);
        // R3: held hw_store level does not restart
        @(negedge clk);
        chk("R3 hw level idle", busy, 1'b0);
        compare_all();
        model_step();

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic s, r, h, p;
            s = ($urandom % 12) == 0;
            r = ($urandom % 12) == 0;
            h = (($urandom % 10) == 0) ? ~hw : hw;
            p = (($urandom % 40) == 0) ? ~sup : sup;
            cyc(s, r, h, p);
        end
        run_idle(E_C + P_C + C_C + L_C + 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule